// File: doc/BRIEF.md
# Byte-Wide CRC-16 Engine with Build-Time Polynomial Choice

This block computes a 16-bit cyclic redundancy check over a stream of bytes, taking one byte on each clock. The feedback network is a flat XOR tree. Each next-state bit is the parity of a fixed group of the current register bits and the incoming data bits. The group for each bit is worked out at elaboration from the plain bit-serial definition of the chosen polynomial. An integer parameter selects one of three generator polynomials. Only the network for that polynomial is built, so the other two cost nothing in the netlist. An out-of-range selection stops elaboration with a fatal message.

Two strobes mark the frame boundaries. The opening strobe comes with the first byte of a frame and replaces the fed-back register with zero, so every frame starts from an all-zero seed. The closing strobe is raised in the cycle after the last byte. In that cycle the checksum of the frame is already on the registered output. The closing strobe then forces both the feedback and the data to zero, which clears the register for the next frame. When no strobe and no valid byte are present, the register keeps its value.

Top module: `crc16_gen`

## Requirements
- R1: A synchronous active-high `rst` clears `crc_out` to 0x0000 at the next rising edge, whatever the strobes and data are doing in that cycle.
- R2: `POLY_SEL` picks the polynomial: 0 (the default) selects 0x8005, 1 selects 0x1021 and 2 selects 0x8BB7. Bits are processed MSB first, with no reflection and no output XOR. For the ASCII bytes "123456789" this gives 0xFEE8, 0x31C3 and 0xD0DB.
- R3: When `byte_vld` is high and neither strobe is high, the register loads the serial CRC step of its own value and `byte_in`, with data bit 7 entering first.
- R4: When `frame_start` is high and `frame_done` is low, the register loads the CRC step of `byte_in` from a zero seed, whatever value it held before.
- R5: The cycle after `frame_done` is high, `crc_out` reads 0x0000, and the value of `byte_in` has no effect on it.
- R6: With `byte_vld`, `frame_start` and `frame_done` all low, `crc_out` keeps its value while `byte_in` changes.
- R7: The checksum of a frame is on `crc_out` in the cycle after its last byte was presented, which is the cycle in which `frame_done` is driven.
- R8: A new frame may open (`frame_start` high) in the cycle right after the `frame_done` cycle. Its checksum is then computed without any loss.
- R9: When `frame_done` is high together with `frame_start` or `byte_vld`, `frame_done` wins and the next value is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | `byte_in` carries a byte of the current frame |
| frame_start | input | 1 | First byte of a frame; seeds the feedback with zero |
| frame_done | input | 1 | Cycle after the last byte; zeroes feedback and data |
| byte_in | input | 8 | Data byte, MSB processed first |
| crc_out | output | 16 | Registered running CRC |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. This is because the only storage between `byte_in` and `crc_out` is the single CRC register. The bench drives inputs on the falling edge and reads `crc_out` at the next falling edge, half a period after the update. A frame's checksum is read in the same falling-edge slot in which `frame_done` is raised. The zero that `frame_done` produces is read one falling edge later, together with the opening byte of a following frame when the frames run back to back. The three parameter settings run side by side on identical stimulus. Each is compared with a bench-side bit-serial model and with the published check values.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam int CRC_W  = 16;
  localparam int DATA_W = 8;
  localparam int VEC_W  = CRC_W + DATA_W;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [VEC_W-1:0]  tap_t;

  localparam crc_t POLY_A = 16'h8005;
  localparam crc_t POLY_B = 16'h1021;
  localparam crc_t POLY_C = 16'h8BB7;

  // One byte through the shift-register definition, bit 7 first.
  function automatic crc_t serial_step(crc_t poly, crc_t seed, byte_t din);
    crc_t c;
    logic fb;
    c = seed;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      fb = c[CRC_W-1] ^ din[b];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  // Dependency set of one next-state bit over {crc, data}, found by
  // pushing each unit vector through the linear serial step.
  function automatic tap_t tap_mask(crc_t poly, int unsigned bit_idx);
    tap_t m;
    tap_t unit;
    crc_t nxt;
    m = '0;
    for (int j = 0; j < VEC_W; j++) begin
      unit    = '0;
      unit[j] = 1'b1;
      nxt     = serial_step(poly, unit[VEC_W-1:DATA_W], unit[DATA_W-1:0]);
      m[j]    = nxt[bit_idx];
    end
    return m;
  endfunction

endpackage

// File: rtl/crc16_xor_net.sv
module crc16_xor_net
  import crc16_pkg::*;
#(
  parameter crc_t POLY = POLY_A
) (
  input  crc_t  crc_cur,
  input  byte_t data_cur,
  output crc_t  crc_nxt
);

  tap_t vec;
  assign vec = {crc_cur, data_cur};

  for (genvar i = 0; i < CRC_W; i++) begin : g_bit
    localparam tap_t TAPS = tap_mask(POLY, i);
    assign crc_nxt[i] = ^(vec & TAPS);
  end

endmodule

// File: rtl/crc16_frame_ctl.sv
module crc16_frame_ctl
  import crc16_pkg::*;
(
  input  logic  byte_vld,
  input  logic  frame_start,
  input  logic  frame_done,
  input  crc_t  crc_q,
  input  byte_t byte_in,
  output crc_t  fb_crc,
  output byte_t fb_data,
  output logic  load_en
);

  always_comb begin
    load_en = byte_vld | frame_start | frame_done;
    fb_crc  = (frame_start | frame_done) ? '0 : crc_q;
    fb_data = frame_done ? '0 : byte_in;
  end

endmodule

// File: rtl/crc16_gen.sv
module crc16_gen
  import crc16_pkg::*;
#(
  parameter int POLY_SEL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_vld,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_out
);

  crc_t  crc_q;
  crc_t  crc_nxt;
  crc_t  fb_crc;
  byte_t fb_data;
  logic  load_en;

  crc16_frame_ctl u_ctl (
    .byte_vld    (byte_vld),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .crc_q       (crc_q),
    .byte_in     (byte_in),
    .fb_crc      (fb_crc),
    .fb_data     (fb_data),
    .load_en     (load_en)
  );

  if (POLY_SEL == 0) begin : g_poly_a
    crc16_xor_net #(.POLY(POLY_A)) u_net (
      .crc_cur(fb_crc), .data_cur(fb_data), .crc_nxt(crc_nxt));
  end else if (POLY_SEL == 1) begin : g_poly_b
    crc16_xor_net #(.POLY(POLY_B)) u_net (
      .crc_cur(fb_crc), .data_cur(fb_data), .crc_nxt(crc_nxt));
  end else if (POLY_SEL == 2) begin : g_poly_c
    crc16_xor_net #(.POLY(POLY_C)) u_net (
      .crc_cur(fb_crc), .data_cur(fb_data), .crc_nxt(crc_nxt));
  end else begin : g_poly_bad
    $fatal(1, "crc16_gen: POLY_SEL must be 0, 1 or 2");
    assign crc_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
    end else if (load_en) begin
      crc_q <= crc_nxt;
    end
  end

  assign crc_out = crc_q;

endmodule

// File: rtl/crc16_gen_chk.sv
module crc16_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        byte_vld,
  input logic        frame_start,
  input logic        frame_done,
  input logic [7:0]  byte_in,
  input logic [15:0] crc_out
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (crc_out == 16'h0000)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!byte_vld && !frame_start && !frame_done) |=> $stable(crc_out)); // R6

  AST_DONE_ZEROES: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (crc_out == 16'h0000)); // R5

  AST_START_ZERO_SEED: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !frame_done && byte_in == 8'h00) |=> (crc_out == 16'h0000)); // R4

  AST_DONE_WINS: assert property (@(posedge clk) disable iff (rst)
    (frame_done && (frame_start || byte_vld)) |=> (crc_out == 16'h0000)); // R9

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(crc_out)); // R3

endmodule

bind crc16_gen crc16_gen_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .byte_vld    (byte_vld),
  .frame_start (frame_start),
  .frame_done  (frame_done),
  .byte_in     (byte_in),
  .crc_out     (crc_out)
);

// File: tb/crc16_gen_tb_top.sv
`timescale 1ns/1ps
module crc16_gen_tb_top;

  typedef logic [7:0] bq_t[$];

  localparam logic [15:0] P0 = 16'h8005;
  localparam logic [15:0] P1 = 16'h1021;
  localparam logic [15:0] P2 = 16'h8BB7;

  logic        clk = 1'b0;
  logic        rst, vld, st, dn;
  logic [7:0]  din;
  logic [15:0] crc_a, crc_b, crc_c;
  logic [15:0] exp_a, exp_b, exp_c;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  crc16_gen dut_i (
    .clk(clk), .rst(rst), .byte_vld(vld), .frame_start(st),
    .frame_done(dn), .byte_in(din), .crc_out(crc_a));
  crc16_gen #(.POLY_SEL(1)) dut_b_i (
    .clk(clk), .rst(rst), .byte_vld(vld), .frame_start(st),
    .frame_done(dn), .byte_in(din), .crc_out(crc_b));
  crc16_gen #(.POLY_SEL(2)) dut_c_i (
    .clk(clk), .rst(rst), .byte_vld(vld), .frame_start(st),
    .frame_done(dn), .byte_in(din), .crc_out(crc_c));

  function automatic logic [15:0] ref_byte(logic [15:0] poly, logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    logic top;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      top = r[15] ^ d[i];
      r   = r << 1;
      if (top) r = r ^ poly;
    end
    return r;
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk3(string req, string what, logic [15:0] ea, logic [15:0] eb, logic [15:0] ec);
    chk(req, {what, " sel0"}, crc_a, ea);
    chk(req, {what, " sel1"}, crc_b, eb);
    chk(req, {what, " sel2"}, crc_c, ec);
  endtask

  task automatic ref_feed(logic [7:0] d);
    exp_a = ref_byte(P0, exp_a, d);
    exp_b = ref_byte(P1, exp_b, d);
    exp_c = ref_byte(P2, exp_c, d);
  endtask

  // Sends a frame; returns with frame_done driven and the result checked.
  task automatic send_frame(bq_t msg, string req);
    @(negedge clk);
    if (dn) chk3("R5", "zero after done", 16'h0, 16'h0, 16'h0);
    dn = 1'b0; st = 1'b1; vld = 1'b1; din = msg[0];
    exp_a = '0; exp_b = '0; exp_c = '0;
    ref_feed(msg[0]);
    for (int k = 1; k < msg.size(); k++) begin
      @(negedge clk);
      st = 1'b0; din = msg[k];
      ref_feed(msg[k]);
    end
    @(negedge clk);
    st = 1'b0; vld = 1'b0; dn = 1'b1; din = 8'hFF;
    chk3(req, "result in done cycle R7", exp_a, exp_b, exp_c);
  endtask

  task automatic finish_idle();
    @(negedge clk);
    chk3("R5", "cleared by done, byte_in=FF ignored", 16'h0, 16'h0, 16'h0);
    dn = 1'b0; din = 8'h00;
  endtask

  task automatic t_reset();
    rst = 1'b1; vld = 1'b1; st = 1'b1; dn = 1'b0; din = 8'hA5;
    repeat (3) @(negedge clk);
    vld = 1'b0; st = 1'b0;
    @(negedge clk);
    chk3("R1", "after reset", 16'h0, 16'h0, 16'h0);
    rst = 1'b0;
  endtask

  task automatic t_check_string();
    bq_t m;
    m = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    send_frame(m, "R2");
    chk3("R2", "check value 123456789", 16'hFEE8, 16'h31C3, 16'hD0DB);
    finish_idle();
  endtask

  task automatic t_single();
    send_frame('{8'h00}, "R3");
    send_frame('{8'hFF}, "R3");
    send_frame('{8'h80}, "R3");
    finish_idle();
  endtask

  task automatic t_idle_hold();
    @(negedge clk);
    st = 1'b1; vld = 1'b1; din = 8'h31;
    exp_a = '0; exp_b = '0; exp_c = '0; ref_feed(8'h31);
    @(negedge clk);
    st = 1'b0; din = 8'h32; ref_feed(8'h32);
    @(negedge clk);
    vld = 1'b0; din = 8'hAA;
    chk3("R3", "two bytes in", exp_a, exp_b, exp_c);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk3("R6", "idle hold", exp_a, exp_b, exp_c);
      din = ~din;
    end
    vld = 1'b1; din = 8'h33; ref_feed(8'h33);
    @(negedge clk);
    vld = 1'b0; dn = 1'b1; din = 8'hFF;
    chk3("R3", "frame across idle gap", exp_a, exp_b, exp_c);
    finish_idle();
  endtask

  task automatic t_restart();
    @(negedge clk);
    st = 1'b1; vld = 1'b1; din = 8'hC3;
    @(negedge clk);
    st = 1'b0; din = 8'h7E;
    @(negedge clk);
    st = 1'b1; din = 8'h42;
    exp_a = '0; exp_b = '0; exp_c = '0; ref_feed(8'h42);
    @(negedge clk);
    st = 1'b0; vld = 1'b0; dn = 1'b1; din = 8'hFF;
    chk3("R4", "start reseeds mid-frame", exp_a, exp_b, exp_c);
    finish_idle();
  endtask

  task automatic t_back2back();
    send_frame('{8'h12, 8'h34, 8'h56}, "R8");
    send_frame('{8'hDE, 8'hAD}, "R8");
    finish_idle();
  endtask

  task automatic t_clash();
    @(negedge clk);
    st = 1'b1; vld = 1'b1; din = 8'h9C;
    @(negedge clk);
    chk("R9", "first byte nonzero", (crc_a != 16'h0) ? 16'h1 : 16'h0, 16'h1);
    st = 1'b1; vld = 1'b1; dn = 1'b1; din = 8'h5A;
    @(negedge clk);
    chk3("R9", "done beats start and valid", 16'h0, 16'h0, 16'h0);
    st = 1'b0; vld = 1'b0; dn = 1'b0;
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    st = 1'b1; vld = 1'b1; din = 8'hE7;
    @(negedge clk);
    st = 1'b0; din = 8'h18; rst = 1'b1;
    @(negedge clk);
    chk3("R1", "reset mid-frame", 16'h0, 16'h0, 16'h0);
    rst = 1'b0; vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete actual=%h expected=%h", 16'h0, 16'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_check_string();
    t_single();
    t_idle_hold();
    t_restart();
    t_back2back();
    t_clash();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule